// File: doc/BRIEF.md
# Stack-relative effective address generator

This unit computes operand addresses for a small 8-bit processor core that has no page-zero addressing. It offers four direct forms and four indirect forms. The direct forms are immediate, stack-relative and two indexed-absolute forms. The indirect forms are absolute-indirect and three forms that take a pointer from the stack. The sequencer takes one request: a mode code, the two operand bytes from the instruction stream and the address of the operand byte. It captures the stack pointer and the selected index register, then runs for a mode-dependent number of cycles. For indirect modes it fetches a 16-bit pointer through a byte-wide read port, low byte first. It finishes with a single-cycle done strobe, the 16-bit address and the number of extra cycles the mode costs.

The unit also owns the 9-bit stack pointer. A separate command input applies a signed 8-bit adjustment or loads the pointer from the accumulator and bit 0 of X. The pointer is always visible as a byte pair, ready to be copied into X (high) and A (low).

Requests use a valid/ready handshake. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the unit is idle. A request held while `req_ready` is low has no effect and is not queued. The result side has no back-pressure. The consumer takes `ea_addr` while `ea_done` is high, or at any time before the next request is taken, because the address is held until then.

Top module: `stkea_unit`

## Requirements
- R1: After reset the stack pointer is 0x1FF, `req_ready` is 1, `ea_done` is 0 and `mem_rd_en` is 0.
- R2: Mode code 0 (immediate) gives `ea_addr` = `req_pc`. `ea_done` rises 1 clock edge after the accepting edge, with `ea_extra` = 0, and no memory read is made.
- R3: Mode code 1 (stack-relative) gives `ea_addr` = {7'b0, (S + op_lo) mod 512}. `ea_done` is due 2 edges after acceptance, with `ea_extra` = 1.
- R4: Mode codes 2 (X-indexed absolute) and 3 (Y-indexed absolute) give `ea_addr` = ({op_hi,op_lo} + X or Y) mod 65536. The index value is the one present at acceptance. `ea_done` is due 3 edges after acceptance, with `ea_extra` = 2, and no memory read is made.
- R5: Mode code 4 (absolute indirect) reads the low pointer byte at {op_hi,op_lo} and then the high byte at the next address, mod 65536. `ea_addr` is that pointer, with no index added. `ea_done` is due 4 edges after acceptance, with `ea_extra` = 3.
- R6: Mode codes 5 (stack indirect), 6 (stack indirect, X-indexed) and 7 (stack indirect, Y-indexed) read the low byte at {7'b0, S+n} and the high byte at {7'b0, S+n+1}, both sums mod 512. `ea_addr` is (pointer + 0, X or Y) mod 65536. `ea_done` is due 4 edges after acceptance, with `ea_extra` = 3.
- R7: `ea_done` is high for exactly one cycle per request, and `ea_addr` keeps its value in the cycle after the strobe.
- R8: From the accepting edge until the edge after `ea_done`, `req_ready` is 0. A request offered in that time does not change the result in progress and is not taken.
- R9: `sp_cmd` = 1 adds `sp_imm`, sign-extended, to S mod 512 on the next edge.
- R10: `sp_cmd` = 2 loads S with {X[0], A} on the next edge.
- R11: `lea_hi` = {7'b0, S[8]} and `lea_lo` = S[7:0] at all times.
- R12: A request taken on the same edge as a stack pointer command uses S from before that command.
- R13: `sp_cmd` = 0 or 3 leaves S unchanged whatever `sp_imm` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address request offered |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_mode | input | 3 | Addressing mode code (0..7) |
| req_op_lo | input | 8 | First operand byte (offset n, or low absolute byte) |
| req_op_hi | input | 8 | Second operand byte (high absolute byte) |
| req_pc | input | 16 | Address of the operand byte, used by immediate mode |
| reg_a | input | 8 | Accumulator, source for the stack pointer load |
| reg_x | input | 8 | X index register |
| reg_y | input | 8 | Y index register |
| sp_cmd | input | 2 | Stack pointer command: 0 hold, 1 adjust, 2 load, 3 hold |
| sp_imm | input | 8 | Signed stack adjustment |
| mem_rd_en | output | 1 | Pointer byte read request |
| mem_addr | output | 16 | Pointer byte address |
| mem_rd_data | input | 8 | Read data, valid the cycle after `mem_rd_en` |
| ea_done | output | 1 | One-cycle completion strobe |
| ea_addr | output | 16 | Computed effective address |
| ea_extra | output | 2 | Extra cycles of the completed mode |
| lea_hi | output | 8 | Stack pointer high byte for X |
| lea_lo | output | 8 | Stack pointer low byte for A |

## Verification
Counted from the edge that takes a request, the completion strobe is due after 1 edge for immediate, 2 for stack-relative, 3 for indexed absolute and 4 for every indirect form. Pointer bytes return one edge after each read request, and stack pointer commands show on `lea_hi`/`lea_lo` one edge later. The bench changes inputs on falling edges and counts falling edges from the accepting one up to the strobe. It compares the count with the expected latency, checks the strobe is gone and the address unchanged one falling edge later, and logs every read address to check the pointer byte order and wrap.

// File: rtl/stkea_pkg.sv
package stkea_pkg;

  typedef enum logic [2:0] {
    AM_IMM   = 3'd0,
    AM_SREL  = 3'd1,
    AM_XABS  = 3'd2,
    AM_YABS  = 3'd3,
    AM_AIND  = 3'd4,
    AM_SIND  = 3'd5,
    AM_SINDX = 3'd6,
    AM_SINDY = 3'd7
  } am_e;

  typedef enum logic [1:0] {
    SPC_HOLD = 2'd0,
    SPC_ADS  = 2'd1,
    SPC_TFA  = 2'd2,
    SPC_RSVD = 2'd3
  } spc_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_P1   = 3'd1,
    PH_P2   = 3'd2,
    PH_P3   = 3'd3,
    PH_DONE = 3'd4
  } ph_e;

  // cycles a mode costs beyond the base instruction time
  function automatic logic [1:0] am_extra(am_e m);
    case (m)
      AM_IMM:            return 2'd0;
      AM_SREL:           return 2'd1;
      AM_XABS, AM_YABS:  return 2'd2;
      default:           return 2'd3;
    endcase
  endfunction

  function automatic logic am_indirect(am_e m);
    return m[2];
  endfunction

  function automatic logic am_uses_x(am_e m);
    return (m == AM_XABS) || (m == AM_SINDX);
  endfunction

  function automatic logic am_uses_y(am_e m);
    return (m == AM_YABS) || (m == AM_SINDY);
  endfunction

endpackage

// File: rtl/stkea_sp.sv
module stkea_sp
  import stkea_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SP_W   = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  spc_e                     cmd,
  input  logic [DATA_W-1:0]        imm,
  input  logic [DATA_W-1:0]        a_in,
  input  logic [SP_W-DATA_W-1:0]   x_low,
  output logic [SP_W-1:0]          sp_q,
  output logic [DATA_W-1:0]        lea_hi,
  output logic [DATA_W-1:0]        lea_lo
);
  localparam int EXT_W = SP_W - DATA_W;
  localparam int PAD_W = 2 * DATA_W - SP_W;

  logic [SP_W-1:0] imm_sx;
  logic [SP_W-1:0] sp_d;

  assign imm_sx = {{EXT_W{imm[DATA_W-1]}}, imm};

  always_comb begin
    sp_d = sp_q;
    case (cmd)
      SPC_ADS: sp_d = sp_q + imm_sx;
      SPC_TFA: sp_d = {x_low, a_in};
      default: sp_d = sp_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sp_q <= {SP_W{1'b1}};
    else        sp_q <= sp_d;
  end

  assign lea_hi = {{PAD_W{1'b0}}, sp_q[SP_W-1:DATA_W]};
  assign lea_lo = sp_q[DATA_W-1:0];

  // R13: no command, no movement of the stack pointer
  assert_sp_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == SPC_HOLD) || (cmd == SPC_RSVD)) |=> $stable(sp_q));

endmodule

// File: rtl/stkea_ctrl.sv
module stkea_ctrl
  import stkea_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  am_e        mode_in,
  output logic       req_ready,
  output logic       accept,
  output ph_e        phase,
  output am_e        mode_q,
  output logic       done,
  output logic [1:0] extra
);
  ph_e        ph_d;
  logic [2:0] lat_q;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign done      = (phase == PH_DONE);
  assign extra     = am_extra(mode_q);

  always_comb begin
    ph_d = phase;
    case (phase)
      PH_IDLE: if (accept) ph_d = (mode_in == AM_IMM) ? PH_DONE : PH_P1;
      PH_P1:   ph_d = (mode_q == AM_SREL) ? PH_DONE : PH_P2;
      PH_P2:   ph_d = am_indirect(mode_q) ? PH_P3 : PH_DONE;
      PH_P3:   ph_d = PH_DONE;
      PH_DONE: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      mode_q <= AM_IMM;
    end else begin
      phase <= ph_d;
      if (accept) mode_q <= mode_in;
    end
  end

  // edges elapsed since the request was taken
  always_ff @(posedge clk) begin
    if (!rst_n)                          lat_q <= 3'd0;
    else if (accept)                     lat_q <= 3'd1;
    else if (phase != PH_IDLE && lat_q != 3'd7) lat_q <= lat_q + 3'd1;
  end

  // R2: strobe lands extra+1 edges after acceptance (covers R3, R4, R5, R6 too)
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == ({1'b0, extra} + 3'd1)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

endmodule

// File: rtl/stkea_path.sv
module stkea_path
  import stkea_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SP_W   = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  am_e                   mode_in,
  input  am_e                   mode_q,
  input  ph_e                   phase,
  input  logic                  done,
  input  logic [DATA_W-1:0]     op_lo,
  input  logic [DATA_W-1:0]     op_hi,
  input  logic [2*DATA_W-1:0]   pc,
  input  logic [SP_W-1:0]       sp_q,
  input  logic [DATA_W-1:0]     x_in,
  input  logic [DATA_W-1:0]     y_in,
  output logic                  mem_rd_en,
  output logic [2*DATA_W-1:0]   mem_addr,
  input  logic [DATA_W-1:0]     mem_rd_data,
  output logic [2*DATA_W-1:0]   ea_addr
);
  localparam int AW    = 2 * DATA_W;
  localparam int ZPAD  = AW - SP_W;

  logic [AW-1:0]     ptr_q, ptr_inc, opw_q, ea_q;
  logic [DATA_W-1:0] idx_q, lo_q;
  logic              cy_q;
  logic [SP_W-1:0]   stk_sum, stk_inc;

  logic [DATA_W-1:0] add_a, add_b;
  logic              add_ci;
  logic [DATA_W:0]   add_s;

  assign stk_sum = sp_q + {{(SP_W-DATA_W){1'b0}}, op_lo};
  assign stk_inc = ptr_q[SP_W-1:0] + 1'b1;
  assign ptr_inc = (mode_q == AM_AIND) ? ptr_q + 1'b1 : {{ZPAD{1'b0}}, stk_inc};

  // one byte-wide adder serves every phase
  always_comb begin
    add_a  = '0;
    add_b  = '0;
    add_ci = 1'b0;
    case (phase)
      PH_P1: begin
        add_a = opw_q[DATA_W-1:0];
        add_b = idx_q;
      end
      PH_P2: begin
        if (am_indirect(mode_q)) begin
          add_a = mem_rd_data;
          add_b = idx_q;
        end else begin
          add_a  = opw_q[AW-1:DATA_W];
          add_ci = cy_q;
        end
      end
      PH_P3: begin
        add_a  = mem_rd_data;
        add_ci = cy_q;
      end
      default: ;
    endcase
  end

  assign add_s = {1'b0, add_a} + {1'b0, add_b} + {{DATA_W{1'b0}}, add_ci};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      opw_q <= '0;
      ea_q  <= '0;
      idx_q <= '0;
      lo_q  <= '0;
      cy_q  <= 1'b0;
    end else begin
      if (accept) begin
        opw_q <= {op_hi, op_lo};
        ptr_q <= (mode_in == AM_AIND) ? {op_hi, op_lo} : {{ZPAD{1'b0}}, stk_sum};
        if (am_uses_x(mode_in))      idx_q <= x_in;
        else if (am_uses_y(mode_in)) idx_q <= y_in;
        else                         idx_q <= '0;
        if (mode_in == AM_IMM) ea_q <= pc;
      end
      case (phase)
        PH_P1: begin
          if (mode_q == AM_SREL)          ea_q <= ptr_q;
          else if (!am_indirect(mode_q)) {cy_q, lo_q} <= add_s;
        end
        PH_P2: begin
          if (am_indirect(mode_q)) {cy_q, lo_q} <= add_s;
          else                     ea_q <= {add_s[DATA_W-1:0], lo_q};
        end
        PH_P3: ea_q <= {add_s[DATA_W-1:0], lo_q};
        default: ;
      endcase
    end
  end

  assign mem_rd_en = am_indirect(mode_q) && ((phase == PH_P1) || (phase == PH_P2));
  assign mem_addr  = (phase == PH_P2) ? ptr_inc : ptr_q;
  assign ea_addr   = ea_q;

  assert_ea_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(ea_addr));

  // R6: second pointer byte sits right after the first (low byte wraps)
  assert_ptr_bytes_adjacent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |->
      (mem_addr[DATA_W-1:0] == $past(mem_addr[DATA_W-1:0]) + 1'b1));

endmodule

// File: rtl/stkea_unit.sv
module stkea_unit
  import stkea_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SP_W   = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [2:0]          req_mode,
  input  logic [DATA_W-1:0]   req_op_lo,
  input  logic [DATA_W-1:0]   req_op_hi,
  input  logic [2*DATA_W-1:0] req_pc,
  input  logic [DATA_W-1:0]   reg_a,
  input  logic [DATA_W-1:0]   reg_x,
  input  logic [DATA_W-1:0]   reg_y,
  input  logic [1:0]          sp_cmd,
  input  logic [DATA_W-1:0]   sp_imm,
  output logic                mem_rd_en,
  output logic [2*DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0]   mem_rd_data,
  output logic                ea_done,
  output logic [2*DATA_W-1:0] ea_addr,
  output logic [1:0]          ea_extra,
  output logic [DATA_W-1:0]   lea_hi,
  output logic [DATA_W-1:0]   lea_lo
);
  localparam int XL_W = SP_W - DATA_W;

  am_e             mode_in, mode_q;
  ph_e             phase;
  logic            accept;
  logic [SP_W-1:0] sp_q;

  assign mode_in = am_e'(req_mode);

  stkea_sp #(.DATA_W(DATA_W), .SP_W(SP_W)) u_sp (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (spc_e'(sp_cmd)),
    .imm    (sp_imm),
    .a_in   (reg_a),
    .x_low  (reg_x[XL_W-1:0]),
    .sp_q   (sp_q),
    .lea_hi (lea_hi),
    .lea_lo (lea_lo)
  );

  stkea_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .mode_in   (mode_in),
    .req_ready (req_ready),
    .accept    (accept),
    .phase     (phase),
    .mode_q    (mode_q),
    .done      (ea_done),
    .extra     (ea_extra)
  );

  stkea_path #(.DATA_W(DATA_W), .SP_W(SP_W)) u_path (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .mode_in     (mode_in),
    .mode_q      (mode_q),
    .phase       (phase),
    .done        (ea_done),
    .op_lo       (req_op_lo),
    .op_hi       (req_op_hi),
    .pc          (req_pc),
    .sp_q        (sp_q),
    .x_in        (reg_x),
    .y_in        (reg_y),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .mem_rd_data (mem_rd_data),
    .ea_addr     (ea_addr)
  );

endmodule

// File: tb/stkea_unit_tb.sv
module stkea_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [2:0]  req_mode;
  logic [7:0]  req_op_lo, req_op_hi;
  logic [15:0] req_pc;
  logic [7:0]  reg_a, reg_x, reg_y;
  logic [1:0]  sp_cmd;
  logic [7:0]  sp_imm;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rd_data = 8'h00;
  logic        ea_done;
  logic [15:0] ea_addr;
  logic [1:0]  ea_extra;
  logic [7:0]  lea_hi, lea_lo;

  int errors = 0;
  int checks = 0;
  int rd_n = 0;
  logic [15:0] rd_log [0:3];

  always #(CLK_PERIOD/2) clk = ~clk;

  stkea_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_op_lo(req_op_lo), .req_op_hi(req_op_hi),
    .req_pc(req_pc), .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y),
    .sp_cmd(sp_cmd), .sp_imm(sp_imm), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .ea_done(ea_done),
    .ea_addr(ea_addr), .ea_extra(ea_extra), .lea_hi(lea_hi), .lea_lo(lea_lo)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] + 8'h3C);
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= memf(mem_addr);
      rd_log[rd_n % 4] <= mem_addr;
      rd_n <= rd_n + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_req(input logic [2:0] m, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [15:0] pc, input logic [1:0] spc, input logic [7:0] spi,
                         output logic [15:0] ea, output int lat, output logic [1:0] ex);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_op_lo = lo; req_op_hi = hi; req_pc = pc;
    sp_cmd = spc; sp_imm = spi;
    @(negedge clk);
    req_valid = 1'b0; sp_cmd = 2'd0;
    lat = 1;
    while (!ea_done && lat < 16) begin
      @(negedge clk);
      lat++;
    end
    ea = ea_addr;
    ex = ea_extra;
    @(negedge clk);
    chk("R7", "strobe gone after one cycle", {31'd0, ea_done}, 32'd0);
    chk("R7", "address held after strobe", {16'd0, ea_addr}, {16'd0, ea});
  endtask

  task automatic sp_do(input logic [1:0] cmd, input logic [7:0] imm,
                       input logic [7:0] a, input logic [7:0] x);
    @(negedge clk);
    sp_cmd = cmd; sp_imm = imm; reg_a = a; reg_x = x;
    @(negedge clk);
    sp_cmd = 2'd0;
  endtask

  task automatic t_reset;
    chk("R1", "ready", {31'd0, req_ready}, 32'd1);
    chk("R1", "done", {31'd0, ea_done}, 32'd0);
    chk("R1", "mem_rd_en", {31'd0, mem_rd_en}, 32'd0);
    chk("R11", "lea pair at reset", {16'd0, lea_hi, lea_lo}, 32'h01FF);
  endtask

  task automatic t_imm;
    logic [15:0] ea; int lat; logic [1:0] ex; int n0;
    n0 = rd_n;
    run_req(3'd0, 8'h77, 8'h66, 16'h1234, 2'd0, 8'h00, ea, lat, ex);
    chk("R2", "immediate address", {16'd0, ea}, 32'h1234);
    chk("R2", "immediate latency", lat, 1);
    chk("R2", "immediate extra", {30'd0, ex}, 32'd0);
    chk("R2", "no read", rd_n - n0, 0);
  endtask

  task automatic t_srel;
    logic [15:0] ea; int lat; logic [1:0] ex;
    run_req(3'd1, 8'h03, 8'h00, 16'h0, 2'd0, 8'h00, ea, lat, ex);
    chk("R3", "s+n wraps in 512", {16'd0, ea}, 32'h0002);
    chk("R3", "s+n latency", lat, 2);
    chk("R3", "s+n extra", {30'd0, ex}, 32'd1);
  endtask

  task automatic t_idx;
    logic [15:0] ea; int lat; logic [1:0] ex; int n0;
    n0 = rd_n;
    @(negedge clk); reg_x = 8'hF0; reg_y = 8'h02;
    run_req(3'd2, 8'h34, 8'h12, 16'h0, 2'd0, 8'h00, ea, lat, ex);
    chk("R4", "X+Abs carry", {16'd0, ea}, 32'h1324);
    chk("R4", "X+Abs latency", lat, 3);
    chk("R4", "X+Abs extra", {30'd0, ex}, 32'd2);
    run_req(3'd3, 8'hFF, 8'hFF, 16'h0, 2'd0, 8'h00, ea, lat, ex);
    chk("R4", "Y+Abs wraps 16 bits", {16'd0, ea}, 32'h0001);
    chk("R4", "Y+Abs latency", lat, 3);
    chk("R4", "no read", rd_n - n0, 0);
  endtask

  task automatic t_aind;
    logic [15:0] ea; int lat; logic [1:0] ex; int n0;
    n0 = rd_n;
    @(negedge clk); reg_x = 8'h55;
    run_req(3'd4, 8'hFF, 8'h20, 16'h0, 2'd0, 8'h00, ea, lat, ex);
    chk("R5", "two reads", rd_n - n0, 2);
    chk("R5", "low byte address", {16'd0, rd_log[n0 % 4]}, 32'h20FF);
    chk("R5", "high byte address", {16'd0, rd_log[(n0 + 1) % 4]}, 32'h2100);
    chk("R5", "pointer, no index", {16'd0, ea}, {16'd0, memf(16'h2100), memf(16'h20FF)});
    chk("R5", "latency", lat, 4);
    chk("R5", "extra", {30'd0, ex}, 32'd3);
  endtask

  task automatic t_sind;
    logic [15:0] ea, p; int lat; logic [1:0] ex; int n0;
    sp_do(2'd2, 8'h00, 8'hFE, 8'h01);
    chk("R10", "load from X0:A", {16'd0, lea_hi, lea_lo}, 32'h01FE);
    n0 = rd_n;
    run_req(3'd5, 8'h01, 8'h00, 16'h0, 2'd0, 8'h00, ea, lat, ex);
    chk("R6", "low byte at S+n", {16'd0, rd_log[n0 % 4]}, 32'h01FF);
    chk("R6", "high byte wraps in 512", {16'd0, rd_log[(n0 + 1) % 4]}, 32'h0000);
    chk("R6", "*s+n pointer", {16'd0, ea}, {16'd0, memf(16'h0000), memf(16'h01FF)});
    chk("R6", "*s+n latency", lat, 4);
    chk("R6", "*s+n extra", {30'd0, ex}, 32'd3);
    @(negedge clk); reg_x = 8'hC0;
    n0 = rd_n;
    run_req(3'd6, 8'h10, 8'h00, 16'h0, 2'd0, 8'h00, ea, lat, ex);
    p = {memf(16'h000F), memf(16'h000E)} + 16'h00C0;
    chk("R6", "*s+n,x low address", {16'd0, rd_log[n0 % 4]}, 32'h000E);
    chk("R6", "*s+n,x indexed", {16'd0, ea}, {16'd0, p});
    @(negedge clk); reg_y = 8'hFF;
    run_req(3'd7, 8'h00, 8'h00, 16'h0, 2'd0, 8'h00, ea, lat, ex);
    p = {memf(16'h01FF), memf(16'h01FE)} + 16'h00FF;
    chk("R6", "*s+n,y indexed", {16'd0, ea}, {16'd0, p});
    chk("R6", "*s+n,y latency", lat, 4);
  endtask

  task automatic t_busy;
    logic [15:0] first; int cyc;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_mode = 3'd2; req_op_lo = 8'h00; req_op_hi = 8'h40; reg_x = 8'h01;
    @(negedge clk);
    req_mode = 3'd0; req_pc = 16'hBEEF;
    cyc = 0;
    while (!ea_done && cyc < 16) begin
      chk("R8", "not ready while busy", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
      cyc++;
    end
    first = ea_addr;
    chk("R8", "held request kept out", {16'd0, first}, 32'h4001);
    chk("R8", "not ready during strobe", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R8", "ready again", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    chk("R8", "no second result", {15'd0, ea_done, ea_addr}, {16'd0, 16'h4001});
  endtask

  task automatic t_ads;
    sp_do(2'd2, 8'h00, 8'hFE, 8'h01);
    sp_do(2'd1, 8'hFC, 8'h00, 8'h00);
    chk("R9", "allocate 4", {16'd0, lea_hi, lea_lo}, 32'h01FA);
    sp_do(2'd1, 8'h04, 8'h00, 8'h00);
    chk("R9", "free 4", {16'd0, lea_hi, lea_lo}, 32'h01FE);
    sp_do(2'd2, 8'h00, 8'h01, 8'h00);
    sp_do(2'd1, 8'hFE, 8'h00, 8'h00);
    chk("R9", "wrap below zero", {16'd0, lea_hi, lea_lo}, 32'h01FF);
    sp_do(2'd3, 8'h55, 8'h12, 8'h00);
    chk("R13", "reserved command holds", {16'd0, lea_hi, lea_lo}, 32'h01FF);
    sp_do(2'd0, 8'h33, 8'h12, 8'h01);
    chk("R13", "hold ignores imm", {16'd0, lea_hi, lea_lo}, 32'h01FF);
  endtask

  task automatic t_snap;
    logic [15:0] ea; int lat; logic [1:0] ex;
    run_req(3'd1, 8'h05, 8'h00, 16'h0, 2'd1, 8'h10, ea, lat, ex);
    chk("R12", "request sees old S", {16'd0, ea}, 32'h0004);
    chk("R12", "S moved afterwards", {16'd0, lea_hi, lea_lo}, 32'h000F);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mode = 3'd0; req_op_lo = 8'h00; req_op_hi = 8'h00;
    req_pc = 16'h0; reg_a = 8'h00; reg_x = 8'h00; reg_y = 8'h00; sp_cmd = 2'd0; sp_imm = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_imm();
    t_srel();
    t_idx();
    t_aind();
    t_sind();
    t_busy();
    t_ads();
    t_snap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule